// File: doc/BRIEF.md
# Spare Area Buffer Distributor

This block turns a NAND page byte stream into write addresses for an on-chip page buffer RAM. A page is moved as a single run of bytes: every main-area byte first, then every spare byte. Main-area bytes land in consecutive 512-byte regions, so sector n occupies offsets n × 0x200 upward. Spare bytes are split into one chunk per 512-byte sector, and each chunk goes to its own 64-byte spare buffer. The spare buffers sit from offset 0x1000 upward.

The chunk length is the spare size divided by the sector count, rounded down to an even number. Rounding can leave some spare bytes unassigned. Those bytes continue in the last used spare buffer, directly after its regular chunk. Software sets the geometry with two inputs: the page size, as the log2 of the sector count, and the spare size, in 16-bit units. The supported geometries are 512+16, 2048+64, 4096+128 and 4096+218 bytes.

A start pulse begins a page transfer. After that, each `byte_en` cycle places one byte. A spare-only start skips the main area and begins at the first spare byte.

Top module: `spare_distributor`

## Requirements
- R1: While `rst_n` is low and after reset, `busy` is 0 and `ram_we` stays 0 even with `byte_en` high.
- R2: After a start with `spare_only`=0, main byte j (j below the page size of 512 << `cfg_sec_log2`) is written to address j, so sector n begins at n × 0x200.
- R3: The first spare byte follows the last main byte and goes to address 0x1000. Spare buffer b begins at 0x1000 + b × 0x40.
- R4: The chunk length is c = ((2 × `cfg_spare_half`) >> `cfg_sec_log2`) rounded down to even. Spare byte k goes to buffer k / c at offset k mod c, for k below (sector count) × c.
- R5: Spare bytes beyond (sector count) × c go to buffer (sector count − 1) at offsets c, c+1, and so on. No buffer index reaches the sector count.
- R6: A start with `spare_only`=1 skips the main area. The first written address is 0x1000, and the transfer holds exactly 2 × `cfg_spare_half` bytes.
- R7: `ram_we` is 1 exactly when `busy` and `byte_en` are both 1. When idle, `byte_en` writes nothing and does not move the position.
- R8: `xfer_last` is 1 on the final byte of the transfer (the page size plus the spare size, counted from the start point), and `busy` is 0 the cycle after.
- R9: A start pulse while `busy` is 1 is ignored, and the address sequence continues unchanged.
- R10: A cycle with `byte_en` low during a transfer holds the position, so `ram_addr` shows the same pending byte address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a page transfer (taken only when idle) |
| spare_only | input | 1 | With start: transfer only the spare area |
| byte_en | input | 1 | One byte moves this cycle |
| cfg_sec_log2 | input | 2 | log2 of sectors per page (0 = 512, 2 = 2048, 3 = 4096 bytes) |
| cfg_spare_half | input | 8 | Spare size in 16-bit units |
| ram_addr | output | 13 | Buffer RAM byte address of the current byte |
| ram_we | output | 1 | Buffer RAM write enable |
| busy | output | 1 | Transfer in progress |
| xfer_last | output | 1 | Current byte is the final one of the transfer |

## Verification
The assertions assume that the geometry inputs stay constant from the start of a transfer until its final byte. They also assume the geometry is one of the supported ones, so every chunk is at least two bytes and fits, together with any leftover, in a 64-byte buffer. The bench changes `cfg_sec_log2` and `cfg_spare_half` only in the cycle of a new start, when `busy` is low. It drives only the four supported geometries. Each byte address is compared with a division-based mapping computed in the bench. The runs cover stalls, spare-only starts and an ignored restart.

// File: rtl/spare_distributor.sv
module spare_distributor #(
  parameter int ADDR_W       = 13,
  parameter int SECTOR_BYTES = 512,
  parameter int NUM_SPARE    = 8,
  parameter int SPARE_BASE   = 4096,
  parameter int SPARE_STRIDE = 64,
  parameter int HALF_W       = 8,
  localparam int SEL_W = $clog2(NUM_SPARE),
  localparam int LOG_W = $clog2(SEL_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              spare_only,
  input  logic              byte_en,
  input  logic [LOG_W-1:0]  cfg_sec_log2,
  input  logic [HALF_W-1:0] cfg_spare_half,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_we,
  output logic              busy,
  output logic              xfer_last
);
  localparam int OFF_W = $clog2(SPARE_STRIDE);
  localparam int SP_W  = HALF_W + 1;

  logic [ADDR_W-1:0] pos;
  logic [SEL_W-1:0]  sbuf;
  logic [OFF_W-1:0]  soff;

  logic [ADDR_W-1:0] page_bytes, end_pos;
  logic [SP_W-1:0]   spare_bytes, chunk;
  logic [SEL_W:0]    sectors;
  logic [SEL_W-1:0]  last_buf;
  logic              in_spare, step, chunk_end;

  assign page_bytes  = ADDR_W'(SECTOR_BYTES) << cfg_sec_log2;
  assign spare_bytes = {cfg_spare_half, 1'b0};
  assign chunk       = (spare_bytes >> cfg_sec_log2) & ~SP_W'(1);
  assign sectors     = (SEL_W+1)'(1) << cfg_sec_log2;
  assign last_buf    = SEL_W'(sectors - 1'b1);
  assign end_pos     = page_bytes + ADDR_W'(spare_bytes) - 1'b1;

  assign in_spare  = pos >= page_bytes;
  assign step      = busy & byte_en;
  assign ram_we    = step;
  assign xfer_last = step && (pos == end_pos);
  assign chunk_end = (SP_W'(soff) == chunk - 1'b1) && (sbuf != last_buf);

  assign ram_addr = in_spare
    ? ADDR_W'(SPARE_BASE) + (ADDR_W'(sbuf) << OFF_W) + ADDR_W'(soff)
    : pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pos  <= '0;
      sbuf <= '0;
      soff <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      pos  <= spare_only ? page_bytes : '0;
      sbuf <= '0;
      soff <= '0;
    end else if (step) begin
      if (xfer_last) busy <= 1'b0;
      pos <= pos + 1'b1;
      if (in_spare) begin
        if (chunk_end) begin
          sbuf <= sbuf + 1'b1;
          soff <= '0;
        end else begin
          soff <= soff + 1'b1;
        end
      end
    end
  end

  // R4
  chunk_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && in_spare && (sbuf != last_buf) |-> SP_W'(soff) < chunk);

  // R5
  last_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> sbuf <= last_buf);

  // R2
  main_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we && !in_spare |-> ram_addr < ADDR_W'(SPARE_BASE));

  // R6
  spare_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && spare_only |=> ram_addr == ADDR_W'(SPARE_BASE));

  // R8
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_last |=> !busy);

  // R9
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !byte_en |=> busy && $stable(ram_addr));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !byte_en |=> $stable(ram_addr));

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !xfer_last |=> $stable(cfg_sec_log2) && $stable(cfg_spare_half));
endmodule

// File: tb/tb_spare_distributor.sv
`timescale 1ns/1ps
module tb_spare_distributor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        spare_only = 1'b0;
  logic        byte_en = 1'b0;
  logic [1:0]  cfg_sec_log2 = '0;
  logic [7:0]  cfg_spare_half = 8'd8;
  logic [12:0] ram_addr;
  logic        ram_we, busy, xfer_last;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  spare_distributor dut (
    .clk(clk), .rst_n(rst_n), .start(start), .spare_only(spare_only),
    .byte_en(byte_en), .cfg_sec_log2(cfg_sec_log2),
    .cfg_spare_half(cfg_spare_half), .ram_addr(ram_addr), .ram_we(ram_we),
    .busy(busy), .xfer_last(xfer_last)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_addr(input int j, input int lg, input int half);
    int page = 512 << lg;
    int sec  = 1 << lg;
    int ch   = ((2 * half) / sec) & ~1;
    int k, b;
    if (j < page) return j;
    k = j - page;
    b = k / ch;
    if (b > sec - 1) b = sec - 1;
    return 4096 + b * 64 + (k - b * ch);
  endfunction

  function automatic string tag_of(input int j, input int lg, input int half,
                                   input bit so, input int first, input int restart_at);
    int page = 512 << lg;
    int sec  = 1 << lg;
    int ch   = ((2 * half) / sec) & ~1;
    if (so && j == first) return "R6";
    if (restart_at >= 0 && j == restart_at + 1) return "R9";
    if (j < page) return "R2";
    if (j == page) return "R3";
    if (j - page < sec * ch) return "R4";
    return "R5";
  endfunction

  task automatic run_page(input int lg, input int half, input bit so,
                          input int stall_every, input int restart_at);
    int page  = 512 << lg;
    int total = page + 2 * half;
    int first = so ? page : 0;
    @(negedge clk);
    cfg_sec_log2 = 2'(lg);
    cfg_spare_half = 8'(half);
    spare_only = so;
    start = 1'b1;
    byte_en = 1'b0;
    @(negedge clk);
    start = 1'b0;
    #1 chk("R8 busy after start", int'(busy), 1);
    for (int j = first; j < total; j++) begin
      if (stall_every > 0 && j % stall_every == 0) begin
        byte_en = 1'b0;
        #1;
        chk("R10 stall we", int'(ram_we), 0);
        chk("R10 stall addr", int'(ram_addr), exp_addr(j, lg, half));
        @(negedge clk);
      end
      byte_en = 1'b1;
      start = (j == restart_at);
      #1;
      chk("R7 we", int'(ram_we), 1);
      chk(tag_of(j, lg, half, so, first, restart_at), int'(ram_addr), exp_addr(j, lg, half));
      chk("R8 last", int'(xfer_last), int'(j == total - 1));
      @(negedge clk);
      start = 1'b0;
    end
    byte_en = 1'b0;
    #1 chk("R8 idle after last", int'(busy), 0);
  endtask

  task automatic test_reset;
    byte_en = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 we in reset", int'(ram_we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 we after reset", int'(ram_we), 0);
    byte_en = 1'b0;
  endtask

  task automatic test_idle_strobe;
    @(negedge clk);
    byte_en = 1'b1;
    repeat (4) begin
      #1 chk("R7 idle we", int'(ram_we), 0);
      @(negedge clk);
    end
    byte_en = 1'b0;
    run_page(0, 8, 1'b0, 0, -1);
  endtask

  initial begin
    test_reset();
    run_page(0, 8, 1'b0, 0, -1);
    run_page(2, 32, 1'b0, 7, -1);
    run_page(3, 64, 1'b0, 0, -1);
    run_page(3, 109, 1'b0, 0, -1);
    run_page(3, 109, 1'b1, 5, -1);
    run_page(2, 32, 1'b1, 0, -1);
    run_page(2, 32, 1'b0, 0, 10);
    test_idle_strobe();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule